// File: doc/BRIEF.md
# DMA channel claim/run controller

This block is the register front end and control logic for a set of memory-to-memory DMA channels. Software reaches it over a simple memory-mapped bus that carries 4-byte and 8-byte accesses. Each channel holds a control word and a staged descriptor: configuration, byte count, destination and source. It also keeps a read-only copy of the descriptor that is currently executing. The data-moving engine sits outside the block. The controller asks the engine to start, copies the staged descriptor into the executing copy when the engine accepts, and records completion or error reported by the engine.

A channel must be claimed before it will run. Claiming a free channel puts the staged descriptor back to its defaults. A claim cannot be given up while the channel is running. Each channel drives two interrupt lines: one for completion and one for error, each gated by its own enable bit.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every control word reads 0, the staged config reads 0x6600_0000, the other staged and executing registers read 0, and all interrupt lines are low.
- R2: The control word at offset 0x000 keeps claim in bit 0, run in bit 1, done-enable in bit 14, error-enable in bit 15, done in bit 30 and error in bit 31. All other bits read 0.
- R3: A control write that takes claim from 0 to 1 sets the staged config to 0x6600_0000, which gives read size (bits 31:28) = 6 and write size (bits 27:24) = 6. The same write clears the staged byte count, destination and source.
- R4: A control write to a channel that was not claimed before the write leaves run at 0 and does not start the engine. The same holds for a write that clears claim while run was 0.
- R5: While run is 1, a control write with claim 0 leaves claim at 1.
- R6: A claimed control write that takes run from 0 to 1 raises the channel's start line on the next cycle. The line stays high until the engine accepts. Acceptance copies the staged config, bytes, destination and source into the executing registers and clears done and error.
- R7: An engine completion pulse clears run and sets done. An engine error pulse sets error and leaves run unchanged.
- R8: Interrupt line 2n is high exactly when channel n has done-enable and done set. Line 2n+1 is high exactly when channel n has error-enable and error set.
- R9: Address bits 11:0 select the register within a channel; the higher bits select the channel. The staged registers are at 0x004 (config), 0x008 (bytes), 0x010 (destination) and 0x018 (source). The executing registers are at 0x104, 0x108, 0x110 and 0x118.
- R10: A 64-bit register can be accessed with one 8-byte access at its base. It can also be accessed as two 4-byte halves, the low half at the base and the high half at base+4.
- R11: Writes to the executing registers have no effect.
- R12: A read returns 0 in three cases: the access size is not 4 or 8, the offset is not defined for that size, or the channel number is out of range. Writes in those cases change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address: channel in upper bits, offset in bits 11:0 |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data; 4-byte writes use bits 31:0 |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 64 | Read data; 4-byte reads return the value in bits 31:0 |
| eng_start_o | output | NUM_CHAN | Start request to the engine, per channel |
| eng_accept_i | input | NUM_CHAN | Engine accepts a pending start |
| eng_done_i | input | NUM_CHAN | Engine completion pulse |
| eng_err_i | input | NUM_CHAN | Engine error pulse |
| eng_cfg_o | output | 32*NUM_CHAN | Executing config, per channel |
| eng_bytes_o | output | 64*NUM_CHAN | Executing byte count, per channel |
| eng_dst_o | output | 64*NUM_CHAN | Executing destination, per channel |
| eng_src_o | output | 64*NUM_CHAN | Executing source, per channel |
| irq_o | output | 2*NUM_CHAN | Done (2n) and error (2n+1) interrupt lines |

## Verification
The claim/run rules are exercised with five control-write patterns: a run request on an unclaimed channel, claiming a channel, claiming and running together, dropping claim while running, and dropping claim while idle. These patterns separate the gate on the old claim value, the forced claim and the idle release. Staged registers are first loaded with non-zero values and then claimed, so a missed default reset is visible. Each 64-bit register is written one way and read the other way (full access against halves), which shows whether the halves are swapped or lost. Done and error are driven on separate channels and with enables on or off, which shows whether each interrupt line is tied to its own enable and status bit.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

   localparam int unsigned OFS_W = 12;
   localparam logic [31:0] CFG_DEFAULT = 32'h6600_0000;

   // control word bit positions
   localparam int unsigned B_CLAIM   = 0;
   localparam int unsigned B_RUN     = 1;
   localparam int unsigned B_DONE_IE = 14;
   localparam int unsigned B_ERR_IE  = 15;
   localparam int unsigned B_DONE    = 30;
   localparam int unsigned B_ERR     = 31;

   typedef enum logic [3:0] {
      RG_CTRL, RG_NCFG, RG_NBYTES, RG_NDST, RG_NSRC,
      RG_XCFG, RG_XBYTES, RG_XDST, RG_XSRC, RG_NONE
   } reg_id_e;

   typedef enum logic [1:0] { PT_LO, PT_HI, PT_FULL } part_e;

   typedef struct packed {
      logic    hit;
      reg_id_e id;
      part_e   part;
   } reg_sel_t;

   function automatic logic [63:0] merge64(logic [63:0] old, logic [63:0] wd, part_e p);
      case (p)
         PT_LO:   return {old[63:32], wd[31:0]};
         PT_HI:   return {wd[31:0], old[31:0]};
         default: return wd;
      endcase
   endfunction

   function automatic logic [63:0] pick64(logic [63:0] v, part_e p);
      case (p)
         PT_LO:   return {32'd0, v[31:0]};
         PT_HI:   return {32'd0, v[63:32]};
         default: return v;
      endcase
   endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
   import dma_ctrl_pkg::*;
(
   input  logic [3:0]       size_i,
   input  logic [OFS_W-1:0] ofs_i,
   output reg_sel_t         sel_o
);
   always_comb begin
      sel_o = '{hit: 1'b1, id: RG_NONE, part: PT_LO};
      if (size_i == 4'd4) begin
         case (ofs_i)
            12'h000: sel_o.id = RG_CTRL;
            12'h004: sel_o.id = RG_NCFG;
            12'h008: sel_o.id = RG_NBYTES;
            12'h00C: begin sel_o.id = RG_NBYTES; sel_o.part = PT_HI; end
            12'h010: sel_o.id = RG_NDST;
            12'h014: begin sel_o.id = RG_NDST;   sel_o.part = PT_HI; end
            12'h018: sel_o.id = RG_NSRC;
            12'h01C: begin sel_o.id = RG_NSRC;   sel_o.part = PT_HI; end
            12'h104: sel_o.id = RG_XCFG;
            12'h108: sel_o.id = RG_XBYTES;
            12'h10C: begin sel_o.id = RG_XBYTES; sel_o.part = PT_HI; end
            12'h110: sel_o.id = RG_XDST;
            12'h114: begin sel_o.id = RG_XDST;   sel_o.part = PT_HI; end
            12'h118: sel_o.id = RG_XSRC;
            12'h11C: begin sel_o.id = RG_XSRC;   sel_o.part = PT_HI; end
            default: sel_o.hit = 1'b0;
         endcase
      end else if (size_i == 4'd8) begin
         sel_o.part = PT_FULL;
         case (ofs_i)
            12'h008: sel_o.id = RG_NBYTES;
            12'h010: sel_o.id = RG_NDST;
            12'h018: sel_o.id = RG_NSRC;
            12'h108: sel_o.id = RG_XBYTES;
            12'h110: sel_o.id = RG_XDST;
            12'h118: sel_o.id = RG_XSRC;
            default: sel_o.hit = 1'b0;
         endcase
      end else begin
         sel_o.hit = 1'b0;
      end
      if (!sel_o.hit) sel_o.id = RG_NONE;
   end

   // R12: a size other than 4 or 8 never decodes to a register
   always_comb begin
      a_r12_bad_size: assert (sel_o.hit == 1'b0 || size_i == 4'd4 || size_i == 4'd8);
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_ctrl_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        wr_i,
   input  reg_sel_t    sel_i,
   input  logic [63:0] wdata_i,
   input  logic        accept_i,
   input  logic        done_i,
   input  logic        err_i,
   output logic [63:0] rd_o,
   output logic        start_o,
   output logic        irq_done_o,
   output logic        irq_err_o,
   output logic [31:0] x_cfg_o,
   output logic [63:0] x_bytes_o,
   output logic [63:0] x_dst_o,
   output logic [63:0] x_src_o
);
   logic        c_claim, c_run, c_done_ie, c_err_ie, c_done, c_err, pend;
   logic [31:0] n_cfg;
   logic [63:0] n_bytes, n_dst, n_src;
   logic        ctrl_wr, w_claim, keep_run, claim_rise, w_run;

   assign ctrl_wr    = wr_i && sel_i.hit && sel_i.id == RG_CTRL;
   assign w_claim    = wdata_i[B_CLAIM] | c_run;                 // R5
   assign keep_run   = c_claim && (c_run || wdata_i[B_CLAIM]);   // R4
   assign claim_rise = !c_claim && wdata_i[B_CLAIM];             // R3
   assign w_run      = wdata_i[B_RUN] && keep_run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         {c_claim, c_run, c_done_ie, c_err_ie, c_done, c_err, pend} <= '0;
         n_cfg <= CFG_DEFAULT;
         n_bytes <= '0; n_dst <= '0; n_src <= '0;
         x_cfg_o <= '0; x_bytes_o <= '0; x_dst_o <= '0; x_src_o <= '0;
      end else begin
         if (ctrl_wr) begin
            if (claim_rise) begin
               n_cfg <= CFG_DEFAULT;
               n_bytes <= '0; n_dst <= '0; n_src <= '0;
            end
            c_claim   <= w_claim;
            c_run     <= w_run;
            c_done_ie <= wdata_i[B_DONE_IE];
            c_err_ie  <= wdata_i[B_ERR_IE];
            c_done    <= wdata_i[B_DONE];
            c_err     <= wdata_i[B_ERR];
            pend      <= w_run && (!c_run || pend);
         end else if (wr_i && sel_i.hit) begin
            case (sel_i.id)
               RG_NCFG:   n_cfg   <= wdata_i[31:0];
               RG_NBYTES: n_bytes <= merge64(n_bytes, wdata_i, sel_i.part);
               RG_NDST:   n_dst   <= merge64(n_dst,   wdata_i, sel_i.part);
               RG_NSRC:   n_src   <= merge64(n_src,   wdata_i, sel_i.part);
               default: ;                                         // R11
            endcase
         end
         if (accept_i && pend) begin                              // R6
            pend <= 1'b0;
            x_cfg_o <= n_cfg; x_bytes_o <= n_bytes;
            x_dst_o <= n_dst; x_src_o <= n_src;
            c_done <= 1'b0; c_err <= 1'b0;
         end
         if (done_i) begin                                        // R7
            c_run <= 1'b0; c_done <= 1'b1; pend <= 1'b0;
         end
         if (err_i) c_err <= 1'b1;
      end
   end

   assign start_o    = pend;
   assign irq_done_o = c_done_ie & c_done;                        // R8
   assign irq_err_o  = c_err_ie & c_err;

   always_comb begin
      rd_o = '0;
      if (sel_i.hit) begin
         case (sel_i.id)
            RG_CTRL: begin
               rd_o[B_CLAIM] = c_claim;  rd_o[B_RUN] = c_run;
               rd_o[B_DONE_IE] = c_done_ie; rd_o[B_ERR_IE] = c_err_ie;
               rd_o[B_DONE] = c_done; rd_o[B_ERR] = c_err;
            end
            RG_NCFG:   rd_o = {32'd0, n_cfg};
            RG_NBYTES: rd_o = pick64(n_bytes, sel_i.part);
            RG_NDST:   rd_o = pick64(n_dst, sel_i.part);
            RG_NSRC:   rd_o = pick64(n_src, sel_i.part);
            RG_XCFG:   rd_o = {32'd0, x_cfg_o};
            RG_XBYTES: rd_o = pick64(x_bytes_o, sel_i.part);
            RG_XDST:   rd_o = pick64(x_dst_o, sel_i.part);
            RG_XSRC:   rd_o = pick64(x_src_o, sel_i.part);
            default:   rd_o = '0;
         endcase
      end
   end

   // R5: a running channel stays claimed on the next cycle
   a_r5_claim_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_run |=> c_claim);
   // R4: a control write on an unclaimed channel never leaves run set
   a_r4_no_run_unclaimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !c_claim && !done_i) |=> !c_run);
   // R3: claim rising comes with default staged registers
   a_r3_claim_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(c_claim) |-> (n_cfg == CFG_DEFAULT && n_bytes == '0 && n_dst == '0 && n_src == '0));
   // R6: start is only requested by a claimed, running channel
   a_r6_start_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> (c_run && c_claim));
   // R7: completion clears run and sets done; error sets error
   a_r7_done_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> (!c_run && c_done));
   a_r7_err_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i |=> c_err);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_ctrl_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 2,
   parameter int unsigned ADDR_W   = 16
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   req_valid_i,
   input  logic                   req_write_i,
   input  logic [ADDR_W-1:0]      req_addr_i,
   input  logic [3:0]             req_size_i,
   input  logic [63:0]            req_wdata_i,
   output logic                   rsp_valid_o,
   output logic [63:0]            rsp_rdata_o,
   output logic [NUM_CHAN-1:0]    eng_start_o,
   input  logic [NUM_CHAN-1:0]    eng_accept_i,
   input  logic [NUM_CHAN-1:0]    eng_done_i,
   input  logic [NUM_CHAN-1:0]    eng_err_i,
   output logic [32*NUM_CHAN-1:0] eng_cfg_o,
   output logic [64*NUM_CHAN-1:0] eng_bytes_o,
   output logic [64*NUM_CHAN-1:0] eng_dst_o,
   output logic [64*NUM_CHAN-1:0] eng_src_o,
   output logic [2*NUM_CHAN-1:0]  irq_o
);
   localparam int unsigned CH_W = ADDR_W - OFS_W;

   if (ADDR_W <= OFS_W) begin : g_chk_addr
      $error("ADDR_W must exceed the per-channel offset width");
   end
   if (NUM_CHAN < 1 || NUM_CHAN > (1 << CH_W)) begin : g_chk_chan
      $error("NUM_CHAN does not fit the channel field");
   end

   logic [CH_W-1:0] ch_idx;
   reg_sel_t        sel;
   logic [63:0]     ch_rd [NUM_CHAN];
   logic [63:0]     rd_mux;

   assign ch_idx = req_addr_i[ADDR_W-1:OFS_W];

   dma_reg_decode u_dec (
      .size_i (req_size_i),
      .ofs_i  (req_addr_i[OFS_W-1:0]),
      .sel_o  (sel)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic wr_here;
      assign wr_here = req_valid_i && req_write_i && ch_idx == CH_W'(c);
      dma_chan_regs u_ch (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .wr_i       (wr_here),
         .sel_i      (sel),
         .wdata_i    (req_wdata_i),
         .accept_i   (eng_accept_i[c]),
         .done_i     (eng_done_i[c]),
         .err_i      (eng_err_i[c]),
         .rd_o       (ch_rd[c]),
         .start_o    (eng_start_o[c]),
         .irq_done_o (irq_o[2*c]),
         .irq_err_o  (irq_o[2*c+1]),
         .x_cfg_o    (eng_cfg_o[32*c +: 32]),
         .x_bytes_o  (eng_bytes_o[64*c +: 64]),
         .x_dst_o    (eng_dst_o[64*c +: 64]),
         .x_src_o    (eng_src_o[64*c +: 64])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CHAN; c++) begin
         if (ch_idx == CH_W'(c)) rd_mux = ch_rd[c];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i && !req_write_i;
         rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      end
   end

   // R12: a read of an undecoded access returns zero
   a_r12_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !req_write_i && !sel.hit) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic [1:0]  start, accept = '0, done = '0, err = '0;
   logic [63:0] e_cfg;
   logic [127:0] e_bytes, e_dst, e_src;
   logic [3:0]  irq;
   int n_run = 0, n_fail = 0;
   logic [63:0] r;

   always #2.5 clk = ~clk;

   dma_chan_ctrl #(.NUM_CHAN(2), .ADDR_W(16)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .eng_start_o(start),
      .eng_accept_i(accept), .eng_done_i(done), .eng_err_i(err),
      .eng_cfg_o(e_cfg), .eng_bytes_o(e_bytes), .eng_dst_o(e_dst), .eng_src_o(e_src),
      .irq_o(irq));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic wr, input int ch, input logic [11:0] ofs,
                      input logic [3:0] sz, input logic [63:0] d, output logic [63:0] rd);
      req_valid = 1'b1; req_write = wr; req_addr = {ch[3:0], ofs};
      req_size = sz; req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rd = rsp_rdata;
   endtask

   task automatic wr32(input int ch, input logic [11:0] o, input logic [31:0] d);
      logic [63:0] x; bus(1'b1, ch, o, 4'd4, {32'd0, d}, x);
   endtask
   task automatic wr64(input int ch, input logic [11:0] o, input logic [63:0] d);
      logic [63:0] x; bus(1'b1, ch, o, 4'd8, d, x);
   endtask
   task automatic rd32(input int ch, input logic [11:0] o, output logic [63:0] v);
      bus(1'b0, ch, o, 4'd4, '0, v);
   endtask
   task automatic rd64(input int ch, input logic [11:0] o, output logic [63:0] v);
      bus(1'b0, ch, o, 4'd8, '0, v);
   endtask
   task automatic pulse(ref logic [1:0] sig, input int ch);
      sig[ch] = 1'b1; @(posedge clk); @(negedge clk); sig[ch] = 1'b0;
   endtask

   task automatic t_reset();
      rd32(0, 12'h000, r); check("R1 ctrl", r, 64'h0);
      rd32(0, 12'h004, r); check("R1 ncfg", r, 64'h6600_0000);
      rd64(1, 12'h108, r); check("R1 xbytes", r, 64'h0);
      check("R1 irq", {60'd0, irq}, 64'h0);
   endtask

   task automatic t_unclaimed_run();
      wr32(0, 12'h000, 32'h0000_0002);
      rd32(0, 12'h000, r); check("R4 run unclaimed", r, 64'h0);
      check("R4 no start", {62'd0, start}, 64'h0);
   endtask

   task automatic t_claim_defaults();
      wr64(0, 12'h008, 64'h1234);
      wr32(0, 12'h004, 32'h11);
      wr64(0, 12'h018, 64'h55);
      wr32(0, 12'h000, 32'h1);
      rd32(0, 12'h004, r); check("R3 cfg default", r, 64'h6600_0000);
      rd64(0, 12'h008, r); check("R3 bytes clear", r, 64'h0);
      rd64(0, 12'h018, r); check("R3 src clear", r, 64'h0);
      rd32(0, 12'h000, r); check("R2 claim bit", r, 64'h1);
   endtask

   task automatic t_halves();
      wr64(0, 12'h010, 64'hA1B2_C3D4_E5F6_0718);
      rd32(0, 12'h010, r); check("R10 dst lo", r, 64'hE5F6_0718);
      rd32(0, 12'h014, r); check("R10 dst hi", r, 64'hA1B2_C3D4);
      wr32(0, 12'h018, 32'h8765_4321);
      wr32(0, 12'h01C, 32'h0000_00FE);
      rd64(0, 12'h018, r); check("R10 src full", r, 64'h0000_00FE_8765_4321);
   endtask

   task automatic t_run_done();
      wr64(0, 12'h008, 64'h100);
      wr32(0, 12'h004, 32'h6600_0004);
      wr32(0, 12'h000, 32'h0000_C003);
      check("R6 start raised", {63'd0, start[0]}, 64'h1);
      rd32(0, 12'h000, r); check("R2 ctrl run", r, 64'hC003);
      accept[0] = 1'b1; @(posedge clk); @(negedge clk); accept[0] = 1'b0;
      check("R6 start dropped", {63'd0, start[0]}, 64'h0);
      rd64(0, 12'h108, r); check("R6 xbytes", r, 64'h100);
      rd32(0, 12'h104, r); check("R9 xcfg", r, 64'h6600_0004);
      check("R6 src port", e_src[63:0], 64'h0000_00FE_8765_4321);
      check("R9 dst port", e_dst[63:0], 64'hA1B2_C3D4_E5F6_0718);
      pulse(done, 0);
      rd32(0, 12'h000, r); check("R7 done", r, 64'h4000_C001);
      check("R8 done line", {60'd0, irq}, 64'h1);
   endtask

   task automatic t_error_and_hold();
      wr32(0, 12'h000, 32'h0000_C003);
      accept[0] = 1'b1; @(posedge clk); @(negedge clk); accept[0] = 1'b0;
      rd32(0, 12'h000, r); check("R6 done cleared", r, 64'hC003);
      pulse(err, 0);
      rd32(0, 12'h000, r); check("R7 err keeps run", r, 64'h8000_C003);
      check("R8 err line", {60'd0, irq}, 64'h2);
      wr32(0, 12'h000, 32'h0000_0000);
      rd32(0, 12'h000, r); check("R5 claim forced", r, 64'h1);
      check("R8 lines low", {60'd0, irq}, 64'h0);
      wr32(0, 12'h000, 32'h0000_0002);
      rd32(0, 12'h000, r); check("R4 drop claim idle", r, 64'h0);
      check("R4 drop no start", {62'd0, start}, 64'h0);
   endtask

   task automatic t_ignored();
      wr32(1, 12'h000, 32'h1);
      wr64(1, 12'h008, 64'h77);
      wr64(1, 12'h108, 64'hDEAD);
      wr32(1, 12'h104, 32'hBEEF);
      rd64(1, 12'h108, r); check("R11 xbytes ignored", r, 64'h0);
      rd32(1, 12'h104, r); check("R11 xcfg ignored", r, 64'h0);
      bus(1'b1, 1, 12'h008, 4'd2, 64'h99, r);
      rd64(1, 12'h008, r); check("R12 bad size write", r, 64'h77);
      bus(1'b0, 1, 12'h008, 4'd2, '0, r); check("R12 bad size read", r, 64'h0);
      wr32(1, 12'h020, 32'h5);
      rd32(1, 12'h020, r); check("R12 bad offset", r, 64'h0);
      rd64(1, 12'h004, r); check("R12 wide cfg", r, 64'h0);
      rd32(3, 12'h000, r); check("R12 bad channel", r, 64'h0);
      wr64(3, 12'h008, 64'h12);
      rd64(1, 12'h008, r); check("R12 bad channel write", r, 64'h77);
   endtask

   task automatic t_chan1_irq();
      wr32(1, 12'h000, 32'h0000_4003);
      check("R6 ch1 start", {62'd0, start}, 64'h2);
      accept[1] = 1'b1; @(posedge clk); @(negedge clk); accept[1] = 1'b0;
      pulse(done, 1);
      check("R8 ch1 lines", {60'd0, irq}, 64'h4);
      pulse(err, 1);
      check("R8 ch1 err disabled", {60'd0, irq}, 64'h4);
      rd32(1, 12'h000, r); check("R7 ch1 ctrl", r, 64'hC000_4001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unclaimed_run();
      t_claim_defaults();
      t_halves();
      t_run_done();
      t_error_and_hold();
      t_ignored();
      t_chan1_irq();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule